// File: doc/BRIEF.md
# System Controller Register File

This block is a write-only, memory-mapped register file on a 32-bit bus that sits in a system controller. It holds the reload values and run/mode settings of four timers, an interrupt pending register with its enable mask, and an indirect configuration window that reaches the base address registers of up to eight expansion-bus devices. Every write word is byte-swapped, reversing its endianness, before it reaches any register. The timers and the devices themselves live elsewhere. This block drives only their reload values, load strobes and control bits, and it keeps the device base address registers itself.

A bus master writes one register per cycle by asserting `wr_en` with an offset and a data word. Interrupt sources set pending bits directly. Software clears pending bits by writing a word whose zero bits mark the bits to drop. The interrupt line is high whenever a pending bit is also enabled. Configuration accesses take two steps. First the master latches an address word that names bus, device, function and register. Then a data write replaces the upper ten address bits of the selected base address register, provided the address decodes to a present device on bus 0, function 0. A side read port returns any stored base address register. Writes to offsets that no register decodes change nothing and raise a one-cycle flag.

Top module: `sysctl_regfile`

## Requirements
- R1: Each write word is byte-swapped before use: the byte in data bits 31:24 lands in register bits 7:0, bits 23:16 in 15:8, bits 15:8 in 23:16, and bits 7:0 in 31:24.
- R2: A write to offset 0x850 + 4*i (i = 0..3) stores the swapped word in reload register i. In the next cycle, and only then, `tmr_load` bit i is high, and no other load bit is high.
- R3: A write to offset 0x864 stores the timer control word. Timer i takes its run bit from register bit 2i and its mode bit from register bit 2i+1.
- R4: Set bits on `int_src` are ORed into the pending register every cycle. A write to offset 0xC18 replaces the pending register with pending AND the swapped word, and a source bit that is set in the same cycle still ends up set.
- R5: A write to offset 0xC1C stores the interrupt mask. `irq` is high exactly when pending AND mask is nonzero, and it follows a pending or mask update in the cycle after the write.
- R6: A write to offset 0xCF8 latches the configuration address, with bus in bits 23:16, device in bits 15:11, function in bits 10:8 and register number in bits 7:0. A later write to offset 0xCFC, with register number 0x10..0x27, replaces bits 31:22 of base address register (reg-0x10)/4 of that device with the swapped word's bits 31:22, and keeps bits 21:0.
- R7: A configuration data write changes no base address register when the bus is nonzero, when the function is nonzero, when the device number is 8 or more, when that device's `dev_present` bit is 0, or when the register number is outside 0x10..0x27.
- R8: A write to any other offset, including a misaligned one, changes no register. It drives `unimpl` high for exactly the next cycle.
- R9: After reset, reload, control, pending, mask and configuration address are zero, `irq`, `unimpl` and `tmr_load` are low, and every base address register holds 0x00000008.
- R10: `bar_rd_data` returns base address register `bar_rd_sel` of device `bar_rd_dev` in the same cycle, and it returns zero for a select value of 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write word, before the byte swap |
| int_src | input | 32 | Interrupt sources, each set bit sets a pending bit |
| dev_present | input | 8 | One bit per device, 1 = present |
| bar_rd_dev | input | 3 | Device number for the base address readout |
| bar_rd_sel | input | 3 | Base address register select for the readout |
| tmr_reload | output | 128 | Reload values, timer i in bits 32i+31:32i |
| tmr_load | output | 4 | One-cycle load strobe per timer |
| tmr_run | output | 4 | Run control bit per timer |
| tmr_mode | output | 4 | Mode control bit per timer |
| int_pending | output | 32 | Pending register |
| irq | output | 1 | Interrupt request |
| unimpl | output | 1 | One-cycle flag for a write to an unmapped offset |
| bar_rd_data | output | 32 | Selected base address register |

## Verification
The hardest case to reach is a configuration data write that lands on a real base address register. It needs an earlier address write whose swapped fields decode to bus 0, function 0 and a present device with an in-range register number. A purely random data word almost never produces that. The stimulus therefore builds address words from chosen fields, mostly legal but sometimes with a nonzero bus or function, absent or out-of-range devices, or register numbers just outside the window. It then byte-swaps them before writing, so the accepted and rejected paths are both exercised many times. A directed case also clears pending bits in the same cycle that a source raises one of them.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

   localparam logic [11:0] OFS_TMR0  = 12'h850;
   localparam logic [11:0] OFS_TCTL  = 12'h864;
   localparam logic [11:0] OFS_PCLR  = 12'hC18;
   localparam logic [11:0] OFS_MASK  = 12'hC1C;
   localparam logic [11:0] OFS_CADDR = 12'hCF8;
   localparam logic [11:0] OFS_CDATA = 12'hCFC;

   localparam logic [7:0]  CFG_BAR_FIRST = 8'h10;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_TMR,
      TGT_TCTL,
      TGT_PCLR,
      TGT_MASK,
      TGT_CADDR,
      TGT_CDATA
   } wr_tgt_e;

   typedef struct packed {
      logic [7:0] bus;
      logic [4:0] dev;
      logic [2:0] fn;
      logic [7:0] reg_no;
   } cfg_addr_t;

endpackage

// File: rtl/sysctl_wr_decode.sv
`timescale 1ns/1ps
module sysctl_wr_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int N_TIMERS = 4,
   localparam int TIDX_W  = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   output wr_tgt_e           tgt,
   output logic [TIDX_W-1:0] tmr_idx,
   output logic [DATA_W-1:0] data_sw
);

   localparam int NBYTES = DATA_W / 8;

   // byte order reversal of the incoming word
   for (genvar b = 0; b < NBYTES; b++) begin : g_swap
      assign data_sw[8*b +: 8] = data_in[8*(NBYTES-1-b) +: 8];
   end

   always_comb begin
      tgt     = TGT_NONE;
      tmr_idx = '0;
      for (int i = 0; i < N_TIMERS; i++) begin
         if (addr == ADDR_W'(OFS_TMR0 + 4*i)) begin
            tgt     = TGT_TMR;
            tmr_idx = TIDX_W'(i);
         end
      end
      if (addr == ADDR_W'(OFS_TCTL))       tgt = TGT_TCTL;
      else if (addr == ADDR_W'(OFS_PCLR))  tgt = TGT_PCLR;
      else if (addr == ADDR_W'(OFS_MASK))  tgt = TGT_MASK;
      else if (addr == ADDR_W'(OFS_CADDR)) tgt = TGT_CADDR;
      else if (addr == ADDR_W'(OFS_CDATA)) tgt = TGT_CDATA;
   end

endmodule

// File: rtl/sysctl_timers.sv
`timescale 1ns/1ps
module sysctl_timers #(
   parameter int N_TIMERS = 4,
   parameter int DATA_W   = 32,
   parameter int TIDX_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_en,
   input  logic [TIDX_W-1:0]          ld_idx,
   input  logic                       ctl_en,
   input  logic [DATA_W-1:0]          data,
   output logic [N_TIMERS*DATA_W-1:0] reload,
   output logic [N_TIMERS-1:0]        load_stb,
   output logic [N_TIMERS-1:0]        run,
   output logic [N_TIMERS-1:0]        mode
);

   localparam int CTL_W = 2 * N_TIMERS;

   logic [CTL_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_en) ctl_q <= data[CTL_W-1:0];
   end

   for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
      logic             sel;
      logic [DATA_W-1:0] reload_q;

      assign sel = ld_en && (ld_idx == TIDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            reload_q    <= '0;
            load_stb[i] <= 1'b0;
         end else begin
            load_stb[i] <= sel;
            if (sel) reload_q <= data;
         end
      end

      assign reload[i*DATA_W +: DATA_W] = reload_q;
      assign run[i]  = ctl_q[2*i];
      assign mode[i] = ctl_q[2*i+1];
   end

endmodule

// File: rtl/sysctl_irq.sv
`timescale 1ns/1ps
module sysctl_irq #(
   parameter int PEND_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic              mask_en,
   input  logic [DATA_W-1:0] data,
   input  logic [PEND_W-1:0] src,
   output logic [PEND_W-1:0] pending,
   output logic              irq
);

   logic [PEND_W-1:0] pend_q;
   logic [PEND_W-1:0] mask_q;
   logic [PEND_W-1:0] keep;

   // a write keeps only the bits that are one in the data word
   assign keep = clr_en ? data[PEND_W-1:0] : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= (pend_q & keep) | src;
         if (mask_en) mask_q <= data[PEND_W-1:0];
      end
   end

   assign pending = pend_q;
   assign irq     = |(pend_q & mask_q);

endmodule

// File: rtl/sysctl_cfg.sv
`timescale 1ns/1ps
module sysctl_cfg
   import sysctl_pkg::*;
#(
   parameter int          N_DEV      = 8,
   parameter int          N_BAR      = 6,
   parameter int          DATA_W     = 32,
   parameter int          BAR_HI_LSB = 22,
   parameter logic [31:0] BAR_RESET  = 32'h0000_0008,
   localparam int         DEV_W      = $clog2(N_DEV),
   localparam int         BAR_IW     = $clog2(N_BAR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              caddr_en,
   input  logic              cdata_en,
   input  logic [DATA_W-1:0] data,
   input  logic [N_DEV-1:0]  dev_present,
   input  logic [DEV_W-1:0]  rd_dev,
   input  logic [BAR_IW-1:0] rd_sel,
   output logic [DATA_W-1:0] rd_data
);

   localparam int NREG = N_DEV * N_BAR;

   cfg_addr_t         cfg_q;
   logic [DEV_W-1:0]  dev_idx;
   logic [BAR_IW-1:0] bar_idx;
   logic              dev_ok;
   logic              reg_ok;
   logic              hit;
   logic [NREG*DATA_W-1:0] bar_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (caddr_en) cfg_q <= data[$bits(cfg_addr_t)-1:0];
   end

   assign dev_idx = cfg_q.dev[DEV_W-1:0];
   assign bar_idx = BAR_IW'((cfg_q.reg_no - CFG_BAR_FIRST) >> 2);
   assign dev_ok  = (int'(cfg_q.dev) < N_DEV) && dev_present[dev_idx];
   assign reg_ok  = (cfg_q.reg_no >= CFG_BAR_FIRST) &&
                    (int'(cfg_q.reg_no) < int'(CFG_BAR_FIRST) + 4*N_BAR);
   assign hit     = cdata_en && (cfg_q.bus == 8'd0) && (cfg_q.fn == 3'd0) &&
                    dev_ok && reg_ok;

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      for (genvar b = 0; b < N_BAR; b++) begin : g_bar
         logic [DATA_W-1:0] bar_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bar_q <= DATA_W'(BAR_RESET);
            else if (hit && dev_idx == DEV_W'(d) && bar_idx == BAR_IW'(b))
               bar_q <= {data[DATA_W-1:BAR_HI_LSB], bar_q[BAR_HI_LSB-1:0]};
         end

         assign bar_flat[(d*N_BAR+b)*DATA_W +: DATA_W] = bar_q;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int d = 0; d < N_DEV; d++) begin
         for (int b = 0; b < N_BAR; b++) begin
            if (rd_dev == DEV_W'(d) && rd_sel == BAR_IW'(b))
               rd_data = bar_flat[(d*N_BAR+b)*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/sysctl_regfile.sv
`timescale 1ns/1ps
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          DATA_W     = 32,
   parameter int          N_TIMERS   = 4,
   parameter int          PEND_W     = 32,
   parameter int          N_DEV      = 8,
   parameter int          N_BAR      = 6,
   parameter int          BAR_HI_LSB = 22,
   parameter logic [31:0] BAR_RESET  = 32'h0000_0008,
   localparam int         DEV_W      = $clog2(N_DEV),
   localparam int         BAR_IW     = $clog2(N_BAR),
   localparam int         TIDX_W     = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [PEND_W-1:0]          int_src,
   input  logic [N_DEV-1:0]           dev_present,
   input  logic [DEV_W-1:0]           bar_rd_dev,
   input  logic [BAR_IW-1:0]          bar_rd_sel,
   output logic [N_TIMERS*DATA_W-1:0] tmr_reload,
   output logic [N_TIMERS-1:0]        tmr_load,
   output logic [N_TIMERS-1:0]        tmr_run,
   output logic [N_TIMERS-1:0]        tmr_mode,
   output logic [PEND_W-1:0]          int_pending,
   output logic                       irq,
   output logic                       unimpl,
   output logic [DATA_W-1:0]          bar_rd_data
);

   // elaboration-time parameter checks
   if (ADDR_W < 12)
      begin : g_bad_addr  $error("ADDR_W must cover offset 0xCFC"); end
   if (DATA_W % 8 != 0 || DATA_W < 24)
      begin : g_bad_data  $error("DATA_W must be whole bytes, at least 24"); end
   if (N_TIMERS < 1 || N_TIMERS > 4)
      begin : g_bad_tmr   $error("N_TIMERS must be 1..4"); end
   if (PEND_W < 1 || PEND_W > DATA_W)
      begin : g_bad_pend  $error("PEND_W must be 1..DATA_W"); end
   if (N_DEV < 2 || N_DEV > 32)
      begin : g_bad_dev   $error("N_DEV must be 2..32"); end
   if (N_BAR < 2 || N_BAR > 8)
      begin : g_bad_bar   $error("N_BAR must be 2..8"); end
   if (BAR_HI_LSB < 1 || BAR_HI_LSB >= DATA_W)
      begin : g_bad_lsb   $error("BAR_HI_LSB out of range"); end

   wr_tgt_e           tgt;
   logic [TIDX_W-1:0] tmr_idx;
   logic [DATA_W-1:0] data_sw;
   logic              unimpl_q;

   sysctl_wr_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .N_TIMERS (N_TIMERS)
   ) i_decode (
      .addr     (wr_addr),
      .data_in  (wr_data),
      .tgt      (tgt),
      .tmr_idx  (tmr_idx),
      .data_sw  (data_sw)
   );

   sysctl_timers #(
      .N_TIMERS (N_TIMERS),
      .DATA_W   (DATA_W),
      .TIDX_W   (TIDX_W)
   ) i_timers (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (wr_en && tgt == TGT_TMR),
      .ld_idx   (tmr_idx),
      .ctl_en   (wr_en && tgt == TGT_TCTL),
      .data     (data_sw),
      .reload   (tmr_reload),
      .load_stb (tmr_load),
      .run      (tmr_run),
      .mode     (tmr_mode)
   );

   sysctl_irq #(
      .PEND_W   (PEND_W),
      .DATA_W   (DATA_W)
   ) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (wr_en && tgt == TGT_PCLR),
      .mask_en  (wr_en && tgt == TGT_MASK),
      .data     (data_sw),
      .src      (int_src),
      .pending  (int_pending),
      .irq      (irq)
   );

   sysctl_cfg #(
      .N_DEV      (N_DEV),
      .N_BAR      (N_BAR),
      .DATA_W     (DATA_W),
      .BAR_HI_LSB (BAR_HI_LSB),
      .BAR_RESET  (BAR_RESET)
   ) i_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .caddr_en    (wr_en && tgt == TGT_CADDR),
      .cdata_en    (wr_en && tgt == TGT_CDATA),
      .data        (data_sw),
      .dev_present (dev_present),
      .rd_dev      (bar_rd_dev),
      .rd_sel      (bar_rd_sel),
      .rd_data     (bar_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) unimpl_q <= 1'b0;
      else        unimpl_q <= wr_en && (tgt == TGT_NONE);
   end

   assign unimpl = unimpl_q;

endmodule

// File: rtl/sysctl_regfile_chk.sv
`timescale 1ns/1ps
module sysctl_regfile_chk
   import sysctl_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int N_TIMERS = 4,
   parameter int PEND_W   = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [PEND_W-1:0]          int_src,
   input logic [N_TIMERS*DATA_W-1:0] tmr_reload,
   input logic [N_TIMERS-1:0]        tmr_load,
   input logic [N_TIMERS-1:0]        tmr_run,
   input logic [N_TIMERS-1:0]        tmr_mode,
   input logic [PEND_W-1:0]          int_pending,
   input logic                       irq,
   input logic                       unimpl
);

   AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tmr_load)); // R2

   for (genvar i = 0; i < N_TIMERS; i++) begin : g_ld
      AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_load[i] |-> $past(wr_en && wr_addr == ADDR_W'(OFS_TMR0 + 4*i))); // R2
   end

   AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_load == '0) |-> $stable(tmr_reload)); // R2

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(wr_en && wr_addr == ADDR_W'(OFS_TCTL))) |-> $stable({tmr_run, tmr_mode})); // R3

   AST_PEND_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(int_src) == '0) |-> ((int_pending & ~$past(int_pending)) == '0)); // R4

   AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(wr_en && wr_addr == ADDR_W'(OFS_PCLR))) |->
         ((int_pending & $past(int_pending)) == $past(int_pending))); // R4

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (int_pending != '0)); // R5

   AST_UNIMPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl |-> $past(wr_en)); // R8

   AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl |-> (tmr_load == '0)); // R8

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .N_TIMERS (N_TIMERS),
   .PEND_W   (PEND_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .int_src     (int_src),
   .tmr_reload  (tmr_reload),
   .tmr_load    (tmr_load),
   .tmr_run     (tmr_run),
   .tmr_mode    (tmr_mode),
   .int_pending (int_pending),
   .irq         (irq),
   .unimpl      (unimpl)
);

// File: tb/test_sysctl_regfile.sv
`timescale 1ns/1ps
module test_sysctl_regfile;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [11:0]  wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic [31:0]  int_src = '0;
   logic [7:0]   dev_present = 8'b1011_0111;   // devices 3 and 6 absent
   logic [2:0]   bar_rd_dev = '0;
   logic [2:0]   bar_rd_sel = '0;
   logic [127:0] tmr_reload;
   logic [3:0]   tmr_load;
   logic [3:0]   tmr_run;
   logic [3:0]   tmr_mode;
   logic [31:0]  int_pending;
   logic         irq;
   logic         unimpl;
   logic [31:0]  bar_rd_data;

   sysctl_regfile i_sysctl_regfile (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .int_src (int_src), .dev_present (dev_present),
      .bar_rd_dev (bar_rd_dev), .bar_rd_sel (bar_rd_sel),
      .tmr_reload (tmr_reload), .tmr_load (tmr_load), .tmr_run (tmr_run),
      .tmr_mode (tmr_mode), .int_pending (int_pending), .irq (irq),
      .unimpl (unimpl), .bar_rd_data (bar_rd_data)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   int  nchk = 0;
   int  nerr = 0;
   bit  done = 1'b0;

   // reference state
   logic [31:0] m_reload [4];
   logic [7:0]  m_ctrl;
   logic [31:0] m_pend;
   logic [31:0] m_mask;
   logic [31:0] m_cfg;
   logic [31:0] m_bar [8][6];
   logic [3:0]  e_load;
   logic        e_unimpl;

   function automatic logic [31:0] swap32(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic bit is_mapped(input logic [11:0] a);
      return (a == 12'h850 || a == 12'h854 || a == 12'h858 || a == 12'h85C ||
              a == 12'h864 || a == 12'hC18 || a == 12'hC1C ||
              a == 12'hCF8 || a == 12'hCFC);
   endfunction

   function automatic logic [31:0] cfg_word(input logic [7:0] bus, input logic [4:0] dev,
                                            input logic [2:0] fn, input logic [7:0] rg);
      return {8'h00, bus, dev, fn, rg};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) m_reload[i] = '0;
      m_ctrl = '0; m_pend = '0; m_mask = '0; m_cfg = '0;
      for (int d = 0; d < 8; d++)
         for (int b = 0; b < 6; b++) m_bar[d][b] = 32'h0000_0008;
      e_load = '0; e_unimpl = 1'b0;
   endtask

   task automatic model_write(input logic [11:0] a, input logic [31:0] d,
                              input logic [31:0] src);
      logic [31:0] s;
      logic [7:0]  bus, rg;
      logic [4:0]  dev;
      logic [2:0]  fn;
      s = swap32(d);
      e_load = '0; e_unimpl = 1'b0;
      if (a == 12'hC18) m_pend = (m_pend & s) | src;
      else              m_pend = m_pend | src;
      case (a)
         12'h850: begin m_reload[0] = s; e_load = 4'b0001; end
         12'h854: begin m_reload[1] = s; e_load = 4'b0010; end
         12'h858: begin m_reload[2] = s; e_load = 4'b0100; end
         12'h85C: begin m_reload[3] = s; e_load = 4'b1000; end
         12'h864: m_ctrl = s[7:0];
         12'hC1C: m_mask = s;
         12'hCF8: m_cfg = s;
         12'hCFC: begin
            bus = m_cfg[23:16]; dev = m_cfg[15:11]; fn = m_cfg[10:8]; rg = m_cfg[7:0];
            if (bus == 0 && fn == 0 && dev < 8 && dev_present[dev[2:0]] &&
                rg >= 8'h10 && rg < 8'h28)
               m_bar[dev][(rg-8'h10)>>2] = {s[31:22], m_bar[dev][(rg-8'h10)>>2][21:0]};
         end
         12'hC18: ;
         default: e_unimpl = 1'b1;
      endcase
   endtask

   task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] src);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; int_src = src;
      @(negedge clk);
      wr_en = 1'b0; int_src = '0;
      model_write(a, d, src);
   endtask

   task automatic do_src(input logic [31:0] src);
      @(negedge clk);
      int_src = src;
      @(negedge clk);
      int_src = '0;
      m_pend = m_pend | src;
      e_load = '0; e_unimpl = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
      e_load = '0; e_unimpl = 1'b0;
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < 4; i++)
         chk("R1/R2", $sformatf("%s reload[%0d]", tag, i), tmr_reload[32*i +: 32], m_reload[i]);
      chk("R2", {tag, " tmr_load"}, 32'(tmr_load), 32'(e_load));
      chk("R3", {tag, " tmr_run"}, 32'(tmr_run), 32'({m_ctrl[6], m_ctrl[4], m_ctrl[2], m_ctrl[0]}));
      chk("R3", {tag, " tmr_mode"}, 32'(tmr_mode), 32'({m_ctrl[7], m_ctrl[5], m_ctrl[3], m_ctrl[1]}));
      chk("R4", {tag, " pending"}, int_pending, m_pend);
      chk("R5", {tag, " irq"}, 32'(irq), 32'(|(m_pend & m_mask)));
      chk("R8", {tag, " unimpl"}, 32'(unimpl), 32'(e_unimpl));
   endtask

   task automatic check_bars(input string tag);
      for (int d = 0; d < 8; d++) begin
         for (int b = 0; b < 8; b++) begin
            bar_rd_dev = 3'(d); bar_rd_sel = 3'(b);
            #0.01;
            chk((b < 6) ? "R6/R7" : "R10", $sformatf("%s bar[%0d][%0d]", tag, d, b),
                bar_rd_data, (b < 6) ? m_bar[d][b] : 32'h0);
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin : main
      logic [11:0] a;
      void'($urandom(32'd20240611));
      model_reset();

      // R9: reset state
      repeat (3) @(negedge clk);
      check_all("R9 reset");
      check_bars("R9 reset");
      rst_n = 1'b1;
      idle();
      check_all("R9 after release");

      // R1 byte swap / R2 load strobe lasts one cycle
      do_wr(12'h850, 32'h1122_3344, '0);
      chk("R1", "swap into reload0", tmr_reload[31:0], 32'h4433_2211);
      check_all("R2 load0");
      idle();
      check_all("R2 strobe dropped");
      do_wr(12'h85C, 32'hDEAD_BEEF, '0);
      check_all("R2 load3");

      // R3 control bit pairs: register 0xB4 -> run 0110, mode 1100
      do_wr(12'h864, swap32(32'h0000_00B4), '0);
      chk("R3", "run pattern", 32'(tmr_run), 32'h6);
      chk("R3", "mode pattern", 32'(tmr_mode), 32'hC);

      // R4 pending set / AND clear / set wins
      do_src(32'hF0F0_00FF);
      check_all("R4 set");
      do_wr(12'hC18, swap32(32'hFFFF_FF0F), '0);
      chk("R4", "and clear", int_pending, 32'hF0F0_000F);
      do_wr(12'hC18, swap32(32'h0), 32'h0000_0001);
      chk("R4", "set beats clear", int_pending, 32'h0000_0001);

      // R5 mask
      do_wr(12'hC1C, swap32(32'h0000_0001), '0);
      chk("R5", "irq on", 32'(irq), 32'h1);
      do_wr(12'hC1C, swap32(32'h0000_0002), '0);
      chk("R5", "irq off", 32'(irq), 32'h0);
      do_src(32'h0000_0002);
      chk("R5", "irq from source", 32'(irq), 32'h1);

      // R6 accepted configuration writes
      do_wr(12'hCF8, swap32(cfg_word(8'd0, 5'd1, 3'd0, 8'h14)), '0);
      do_wr(12'hCFC, swap32(32'hFFFF_FFFF), '0);
      bar_rd_dev = 3'd1; bar_rd_sel = 3'd1; #0.01;
      chk("R6", "bar1.1 upper bits only", bar_rd_data, 32'hFFC0_0008);
      do_wr(12'hCF8, swap32(cfg_word(8'd0, 5'd7, 3'd0, 8'h27)), '0);
      do_wr(12'hCFC, swap32(32'hA5A5_A5A5), '0);
      do_wr(12'hCF8, swap32(cfg_word(8'd0, 5'd0, 3'd0, 8'h12)), '0);
      do_wr(12'hCFC, swap32(32'h1234_5678), '0);
      check_bars("R6 directed");

      // R7 rejected configuration writes
      do_wr(12'hCF8, swap32(cfg_word(8'd1, 5'd2, 3'd0, 8'h10)), '0);
      do_wr(12'hCFC, swap32(32'hFFFF_FFFF), '0);
      do_wr(12'hCF8, swap32(cfg_word(8'd0, 5'd2, 3'd1, 8'h10)), '0);
      do_wr(12'hCFC, swap32(32'hFFFF_FFFF), '0);
      do_wr(12'hCF8, swap32(cfg_word(8'd0, 5'd3, 3'd0, 8'h10)), '0);
      do_wr(12'hCFC, swap32(32'hFFFF_FFFF), '0);
      do_wr(12'hCF8, swap32(cfg_word(8'd0, 5'd9, 3'd0, 8'h10)), '0);
      do_wr(12'hCFC, swap32(32'hFFFF_FFFF), '0);
      do_wr(12'hCF8, swap32(cfg_word(8'd0, 5'd2, 3'd0, 8'h28)), '0);
      do_wr(12'hCFC, swap32(32'hFFFF_FFFF), '0);
      do_wr(12'hCF8, swap32(cfg_word(8'd0, 5'd2, 3'd0, 8'h0C)), '0);
      do_wr(12'hCFC, swap32(32'hFFFF_FFFF), '0);
      check_bars("R7 rejected");

      // R8 unmapped offsets
      do_wr(12'h851, 32'hFFFF_FFFF, '0);
      check_all("R8 misaligned");
      idle();
      check_all("R8 flag dropped");
      do_wr(12'h860, 32'hFFFF_FFFF, '0);
      check_all("R8 gap");
      do_wr(12'hCF4, 32'hFFFF_FFFF, '0);
      check_all("R8 near cfg");

      // constrained random mix
      for (int k = 0; k < 600; k++) begin
         int unsigned r;
         logic [31:0] src;
         r   = $urandom % 11;
         src = ($urandom % 6 == 0) ? (32'(1) << ($urandom % 32)) : 32'h0;
         case (r)
            0, 1:    do_wr(12'h850 + 12'(4 * ($urandom % 4)), $urandom, src);
            2:       do_wr(12'h864, $urandom, src);
            3:       do_wr(12'hC18, $urandom | $urandom, src);
            4:       do_wr(12'hC1C, $urandom, src);
            5, 6: begin
               logic [7:0] bus, rg;
               logic [2:0] fn;
               logic [4:0] dev;
               bus = ($urandom % 5 == 0) ? 8'($urandom) : 8'd0;
               fn  = ($urandom % 5 == 0) ? 3'($urandom) : 3'd0;
               dev = 5'($urandom % 11);
               rg  = 8'h08 + 8'($urandom % 40);
               do_wr(12'hCF8, swap32({8'($urandom), bus, dev, fn, rg}), src);
            end
            7, 8:    do_wr(12'hCFC, $urandom, src);
            9: begin
               a = 12'($urandom);
               if (is_mapped(a)) a = 12'h100;
               do_wr(a, $urandom, src);
            end
            default: do_src(32'($urandom));
         endcase
         check_all("random");
         if (k % 100 == 99) check_bars("random");
      end
      check_bars("final");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule